// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM with Cross-Port Mailbox Interrupts

This block is a synchronous true dual-port word memory shared by two agents, called the left and the right side. Each side has its own select, read/write strobe, output enable, two byte-lane enables, address, write data and read data. Both sides may read or write any word in the same clock cycle. Each 16-bit word is held as two independent 8-bit lanes, so a side can write or read either byte alone.

The two highest word addresses double as mailboxes. The word just below the top belongs to the left side. When the right side writes it, the left side's active-low interrupt output goes low. The left side releases that interrupt by reading the word. The top word works the same way with the roles swapped. Mailbox words keep whatever data is written to them and behave as ordinary storage. Each side has an active-low hold input, driven by external arbitration, that freezes any interrupt change that side would cause. It does not block that side's storage access.

The depth is set by the address-width parameter: 1024 words by default, and 8192 words at 13 bits, where the mailboxes sit at 0x1FFE (left) and 0x1FFF (right). Reads are registered, so data and lane-valid bits appear one clock after the request.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: During and after synchronous reset, both interrupt outputs are high, both lane-valid outputs are 2'b00 and both read data outputs are zero.
- R2: A write cycle (select low, rw low) updates only the lanes whose enable is low. Upper enable covers bits 15:8 (lane bit 1) and lower enable covers bits 7:0 (lane bit 0).
- R3: A read cycle (select low, rw high) with output enable low presents, one clock later, the stored lanes whose enable was low. Each such lane has its lane-valid bit set. Every other lane reads as zero with a cleared valid bit. With output enable high, both lanes read zero and are not valid.
- R4: With select high, a side neither writes storage nor drives data, whatever its other inputs are.
- R5: A right-side write to address DEPTH-2 drives the left interrupt low one clock later.
- R6: A left-side read of address DEPTH-2 returns the left interrupt high one clock later.
- R7: A left-side write to address DEPTH-1 drives the right interrupt low. A right-side read of DEPTH-1 returns it high. Each takes effect one clock later.
- R8: While a side's hold input is low, a mailbox write or read by that side leaves the interrupt flag unchanged.
- R9: Mailbox words store and return written data like any other word.
- R10: When a setting write and a clearing read of the same mailbox occur in the same cycle, the interrupt is set.
- R11: When both sides write the same word in the same cycle, the left side's data is stored on each lane both sides enable.
- R12: A read that coincides with the other side's write to the same word returns the data held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_cs_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper lane enable, active low |
| l_lb_n | input | 1 | Left lower lane enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_hold_n | input | 1 | Left hold, active low, freezes flag changes by left |
| l_rdata | output | 16 | Left read data, zero on lanes not driven |
| l_lane_vld | output | 2 | Left lanes currently driven {upper, lower} |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper lane enable, active low |
| r_lb_n | input | 1 | Right lower lane enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_hold_n | input | 1 | Right hold, active low, freezes flag changes by right |
| r_rdata | output | 16 | Right read data, zero on lanes not driven |
| r_lane_vld | output | 2 | Right lanes currently driven {upper, lower} |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
A corrupted interrupt flag shows at the interrupt pin on the very next clock. The flag is a single register that drives the pin directly, so a missed set, a missed clear or a hold that fails to block is visible one edge after the cycle that caused it. A wrong lane-write mask or wrong write priority stays hidden until the word is read back. It then shows as one wrong byte in the read data one clock after that read. The bench therefore pairs every write pattern with an explicit read-back. A wrong read-ordering choice shows only when a read and a write to the same word fall in the same cycle, so the bench creates that collision on purpose.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int LANE_BITS = 8;
    localparam int LANES     = 2;
    localparam int WORD_BITS = LANE_BITS * LANES;

    // Decoded view of one side's request for a single cycle
    typedef struct packed {
        logic sel;      // side selected
        logic wr;       // write cycle
        logic rd;       // read cycle
        logic free;     // hold input released
    } side_acc_t;

    // Lane enable vector from the per-lane active-low enables
    function automatic logic [LANES-1:0] lane_mask(input logic ub_n, input logic lb_n);
        return {~ub_n, ~lb_n};
    endfunction

    // Slice one lane of a word
    function automatic logic [LANE_BITS-1:0] lane_of(input logic [WORD_BITS-1:0] w,
                                                     input int idx);
        return w[idx*LANE_BITS +: LANE_BITS];
    endfunction

endpackage

// File: rtl/dpr_side_dec.sv
module dpr_side_dec
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 cs_n,
    input  logic                 rw,
    input  logic                 oe_n,
    input  logic                 ub_n,
    input  logic                 lb_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 hold_n,
    output side_acc_t            acc,
    output logic [LANES-1:0]     wr_lane,
    output logic [LANES-1:0]     drv_lane,
    output logic                 hit_left_box,
    output logic                 hit_right_box
);
    localparam logic [ADDR_W-1:0] BOX_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_RIGHT = {ADDR_W{1'b1}};

    logic [LANES-1:0] en;

    always_comb begin
        en        = lane_mask(ub_n, lb_n);
        acc.sel   = ~cs_n;
        acc.wr    = ~cs_n & ~rw;
        acc.rd    = ~cs_n &  rw;
        acc.free  = hold_n;
        wr_lane   = acc.wr ? en : '0;
        drv_lane  = (acc.rd & ~oe_n) ? en : '0;
        hit_left_box  = (addr == BOX_LEFT);
        hit_right_box = (addr == BOX_RIGHT);
    end

endmodule

// File: rtl/dpr_lane_ram.sv
module dpr_lane_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  l_we,
    input  logic                  l_re,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [LANE_BITS-1:0]  l_wd,
    output logic [LANE_BITS-1:0]  l_rd,
    input  logic                  r_we,
    input  logic                  r_re,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [LANE_BITS-1:0]  r_wd,
    output logic [LANE_BITS-1:0]  r_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_BITS-1:0] cells [DEPTH];

    // Right write first, left write last: left wins on a shared word.
    always_ff @(posedge clk) begin
        if (r_we) cells[r_addr] <= r_wd;
        if (l_we) cells[l_addr] <= l_wd;
    end

    // Registered reads sample the array before this edge's writes land.
    always_ff @(posedge clk) begin
        if (l_re) l_rd <= cells[l_addr];
        if (r_re) r_rd <= cells[r_addr];
    end

endmodule

// File: rtl/dpr_box_flag.sv
module dpr_box_flag (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic drop,
    output logic flag_n
);
    always_ff @(posedge clk) begin
        if (rst)        flag_n <= 1'b1;
        else if (raise) flag_n <= 1'b0;
        else if (drop)  flag_n <= 1'b1;
    end
endmodule

// File: rtl/dpr_mailbox_ram.sv
module dpr_mailbox_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  l_cs_n,
    input  logic                  l_rw,
    input  logic                  l_oe_n,
    input  logic                  l_ub_n,
    input  logic                  l_lb_n,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [WORD_BITS-1:0]  l_wdata,
    input  logic                  l_hold_n,
    output logic [WORD_BITS-1:0]  l_rdata,
    output logic [LANES-1:0]      l_lane_vld,
    output logic                  l_int_n,
    input  logic                  r_cs_n,
    input  logic                  r_rw,
    input  logic                  r_oe_n,
    input  logic                  r_ub_n,
    input  logic                  r_lb_n,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [WORD_BITS-1:0]  r_wdata,
    input  logic                  r_hold_n,
    output logic [WORD_BITS-1:0]  r_rdata,
    output logic [LANES-1:0]      r_lane_vld,
    output logic                  r_int_n
);
    side_acc_t        l_acc, r_acc;
    logic [LANES-1:0] l_wl, r_wl, l_dl, r_dl;
    logic             l_hit_lb, l_hit_rb, r_hit_lb, r_hit_rb;
    logic [WORD_BITS-1:0] l_word, r_word;
    logic [LANES-1:0] l_vld_q, r_vld_q;

    dpr_side_dec #(.ADDR_W(ADDR_W)) u_dec_l (
        .cs_n(l_cs_n), .rw(l_rw), .oe_n(l_oe_n), .ub_n(l_ub_n), .lb_n(l_lb_n),
        .addr(l_addr), .hold_n(l_hold_n), .acc(l_acc), .wr_lane(l_wl),
        .drv_lane(l_dl), .hit_left_box(l_hit_lb), .hit_right_box(l_hit_rb)
    );

    dpr_side_dec #(.ADDR_W(ADDR_W)) u_dec_r (
        .cs_n(r_cs_n), .rw(r_rw), .oe_n(r_oe_n), .ub_n(r_ub_n), .lb_n(r_lb_n),
        .addr(r_addr), .hold_n(r_hold_n), .acc(r_acc), .wr_lane(r_wl),
        .drv_lane(r_dl), .hit_left_box(r_hit_lb), .hit_right_box(r_hit_rb)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpr_lane_ram #(.ADDR_W(ADDR_W)) u_lane (
            .clk   (clk),
            .l_we  (l_wl[g]),
            .l_re  (l_acc.rd),
            .l_addr(l_addr),
            .l_wd  (lane_of(l_wdata, g)),
            .l_rd  (l_word[g*LANE_BITS +: LANE_BITS]),
            .r_we  (r_wl[g]),
            .r_re  (r_acc.rd),
            .r_addr(r_addr),
            .r_wd  (lane_of(r_wdata, g)),
            .r_rd  (r_word[g*LANE_BITS +: LANE_BITS])
        );

        assign l_rdata[g*LANE_BITS +: LANE_BITS] = l_vld_q[g] ? l_word[g*LANE_BITS +: LANE_BITS] : '0;
        assign r_rdata[g*LANE_BITS +: LANE_BITS] = r_vld_q[g] ? r_word[g*LANE_BITS +: LANE_BITS] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_vld_q <= '0;
            r_vld_q <= '0;
        end else begin
            l_vld_q <= l_dl;
            r_vld_q <= r_dl;
        end
    end

    assign l_lane_vld = l_vld_q;
    assign r_lane_vld = r_vld_q;

    // Left flag: raised by a right write to the left box, dropped by a left read of it
    dpr_box_flag u_flag_l (
        .clk   (clk),
        .rst   (rst),
        .raise (r_acc.wr & r_hit_lb & r_acc.free),
        .drop  (l_acc.rd & l_hit_lb & l_acc.free),
        .flag_n(l_int_n)
    );

    // Right flag: raised by a left write to the right box, dropped by a right read of it
    dpr_box_flag u_flag_r (
        .clk   (clk),
        .rst   (rst),
        .raise (l_acc.wr & l_hit_rb & l_acc.free),
        .drop  (r_acc.rd & r_hit_rb & r_acc.free),
        .flag_n(r_int_n)
    );

endmodule

// File: rtl/dpr_mailbox_ram_chk.sv
module dpr_mailbox_ram_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs_n,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic              l_ub_n,
    input logic              l_lb_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [15:0]       l_wdata,
    input logic              l_hold_n,
    input logic [15:0]       l_rdata,
    input logic [1:0]        l_lane_vld,
    input logic              l_int_n,
    input logic              r_cs_n,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic              r_ub_n,
    input logic              r_lb_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [15:0]       r_wdata,
    input logic              r_hold_n,
    input logic [15:0]       r_rdata,
    input logic [1:0]        r_lane_vld,
    input logic              r_int_n
);
    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    logic set_l, clr_l, set_r, clr_r;
    assign set_l = !r_cs_n && !r_rw && (r_addr == BOX_L) && r_hold_n;
    assign clr_l = !l_cs_n &&  l_rw && (l_addr == BOX_L) && l_hold_n;
    assign set_r = !l_cs_n && !l_rw && (l_addr == BOX_R) && l_hold_n;
    assign clr_r = !r_cs_n &&  r_rw && (r_addr == BOX_R) && r_hold_n;

    a_r5_left_raise: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !l_int_n);

    a_r6_left_release: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !set_l) |=> l_int_n);

    a_r7_right_raise: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !r_int_n);

    a_r7_right_release: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !set_r) |=> r_int_n);

    a_r8_left_frozen: assert property (@(posedge clk) disable iff (rst)
        (!set_l && !clr_l) |=> $stable(l_int_n));

    a_r8_right_frozen: assert property (@(posedge clk) disable iff (rst)
        (!set_r && !clr_r) |=> $stable(r_int_n));

    a_r4_left_quiet: assert property (@(posedge clk) disable iff (rst)
        l_cs_n |=> (l_lane_vld == 2'b00));

    a_r3_right_oe_off: assert property (@(posedge clk) disable iff (rst)
        r_oe_n |=> (r_lane_vld == 2'b00 && r_rdata == 16'h0000));

endmodule

bind dpr_mailbox_ram dpr_mailbox_ram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dpr_mailbox_ram.sv
`timescale 1ns/1ps
module tb_dpr_mailbox_ram;
    localparam int ADDR_W = 10;
    localparam logic [ADDR_W-1:0] BOX_L = (1 << ADDR_W) - 2;
    localparam logic [ADDR_W-1:0] BOX_R = (1 << ADDR_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_cs_n, l_rw, l_oe_n, l_ub_n, l_lb_n, l_hold_n;
    logic r_cs_n, r_rw, r_oe_n, r_ub_n, r_lb_n, r_hold_n;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic [1:0]  l_lane_vld, r_lane_vld;
    logic        l_int_n, r_int_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dpr_mailbox_ram #(.ADDR_W(ADDR_W)) dut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_cs_n = 1; l_rw = 1; l_oe_n = 1; l_ub_n = 1; l_lb_n = 1; l_hold_n = 1;
        r_cs_n = 1; r_rw = 1; r_oe_n = 1; r_ub_n = 1; r_lb_n = 1; r_hold_n = 1;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    task automatic lwr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input bit up, input bit lo);
        l_cs_n = 0; l_rw = 0; l_addr = a; l_wdata = d; l_ub_n = !up; l_lb_n = !lo;
    endtask
    task automatic rwr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input bit up, input bit lo);
        r_cs_n = 0; r_rw = 0; r_addr = a; r_wdata = d; r_ub_n = !up; r_lb_n = !lo;
    endtask
    task automatic lrd(input logic [ADDR_W-1:0] a, input bit up, input bit lo, input bit oe);
        l_cs_n = 0; l_rw = 1; l_addr = a; l_ub_n = !up; l_lb_n = !lo; l_oe_n = !oe;
    endtask
    task automatic rrd(input logic [ADDR_W-1:0] a, input bit up, input bit lo, input bit oe);
        r_cs_n = 0; r_rw = 1; r_addr = a; r_ub_n = !up; r_lb_n = !lo; r_oe_n = !oe;
    endtask

    // Inputs applied at a falling edge are captured at the next rising edge;
    // outputs are sampled at the following falling edge, before new inputs.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 l_int_n", {15'd0, l_int_n}, 16'h0001);
        chk("R1 r_int_n", {15'd0, r_int_n}, 16'h0001);
        chk("R1 lane_vld", {12'd0, l_lane_vld, r_lane_vld}, 16'h0000);
        chk("R1 rdata", l_rdata | r_rdata, 16'h0000);
    endtask

    task automatic t_lanes();
        idle(); lwr(10'h010, 16'hA5C3, 1, 1); step();
        idle(); rrd(10'h010, 1, 1, 1); step();
        chk("R2/R3 full read", r_rdata, 16'hA5C3);
        chk("R3 both lanes valid", {14'd0, r_lane_vld}, 16'h0003);
        idle(); lwr(10'h010, 16'h1234, 1, 0); step();
        idle(); rrd(10'h010, 1, 1, 1); step();
        chk("R2 upper-only write", r_rdata, 16'h12C3);
        idle(); rrd(10'h010, 0, 1, 1); step();
        chk("R3 lower-only read", r_rdata, 16'h00C3);
        chk("R3 lower lane valid", {14'd0, r_lane_vld}, 16'h0001);
        idle(); lwr(10'h010, 16'hFF5A, 0, 1); step();
        idle(); lrd(10'h010, 1, 0, 1); step();
        chk("R3 upper-only read", l_rdata, 16'h1200);
        chk("R3 upper lane valid", {14'd0, l_lane_vld}, 16'h0002);
        idle(); rrd(10'h010, 1, 1, 0); step();
        chk("R3 oe high data", r_rdata, 16'h0000);
        chk("R3 oe high valid", {14'd0, r_lane_vld}, 16'h0000);
        idle(); lrd(10'h010, 1, 1, 1); step();
        chk("R2 lower-only write", l_rdata, 16'h125A);
    endtask

    task automatic t_deselect();
        idle(); lwr(10'h010, 16'hFFFF, 1, 1); l_cs_n = 1; step();
        idle(); rrd(10'h010, 1, 1, 1); r_cs_n = 1; step();
        chk("R4 deselected read valid", {14'd0, r_lane_vld}, 16'h0000);
        chk("R4 deselected read data", r_rdata, 16'h0000);
        idle(); rrd(10'h010, 1, 1, 1); step();
        chk("R4 deselected write ignored", r_rdata, 16'h125A);
    endtask

    task automatic t_box_left();
        idle(); rwr(BOX_L, 16'hBEEF, 1, 1); step();
        chk("R5 left int raised", {15'd0, l_int_n}, 16'h0000);
        chk("R5 right int untouched", {15'd0, r_int_n}, 16'h0001);
        idle(); step();
        chk("R5 left int stays low", {15'd0, l_int_n}, 16'h0000);
        idle(); lrd(BOX_L, 1, 1, 1); step();
        chk("R9 left box data", l_rdata, 16'hBEEF);
        chk("R6 left int released", {15'd0, l_int_n}, 16'h0001);
    endtask

    task automatic t_box_right();
        idle(); lwr(BOX_R, 16'h0F0F, 1, 1); step();
        chk("R7 right int raised", {15'd0, r_int_n}, 16'h0000);
        chk("R7 left int untouched", {15'd0, l_int_n}, 16'h0001);
        idle(); rrd(BOX_R, 1, 1, 1); step();
        chk("R9 right box data", r_rdata, 16'h0F0F);
        chk("R7 right int released", {15'd0, r_int_n}, 16'h0001);
    endtask

    task automatic t_hold();
        idle(); rwr(BOX_L, 16'hCAFE, 1, 1); r_hold_n = 0; step();
        chk("R8 held write no raise", {15'd0, l_int_n}, 16'h0001);
        idle(); lrd(BOX_L, 1, 1, 1); step();
        chk("R9 held write still stored", l_rdata, 16'hCAFE);
        idle(); rwr(BOX_L, 16'hD00D, 1, 1); step();
        chk("R5 raise after hold", {15'd0, l_int_n}, 16'h0000);
        idle(); lrd(BOX_L, 1, 1, 1); l_hold_n = 0; step();
        chk("R8 held read no release", {15'd0, l_int_n}, 16'h0000);
        idle(); lrd(BOX_L, 1, 1, 1); step();
        chk("R6 release after hold", {15'd0, l_int_n}, 16'h0001);
    endtask

    task automatic t_priority();
        idle(); rwr(BOX_L, 16'h7777, 1, 1); lrd(BOX_L, 1, 1, 1); step();
        chk("R10 set beats clear", {15'd0, l_int_n}, 16'h0000);
        chk("R12 box read old data", l_rdata, 16'hD00D);
        idle(); lrd(BOX_L, 1, 1, 1); step();
        chk("R6 release after tie", {15'd0, l_int_n}, 16'h0001);
        chk("R9 box new data", l_rdata, 16'h7777);
    endtask

    task automatic t_collide();
        idle(); lwr(10'h020, 16'hAAAA, 1, 1); rwr(10'h020, 16'h5555, 1, 1); step();
        idle(); rrd(10'h020, 1, 1, 1); step();
        chk("R11 left wins same word", r_rdata, 16'hAAAA);
        idle(); lwr(10'h021, 16'h1100, 1, 0); rwr(10'h021, 16'h22EE, 1, 1); step();
        idle(); lrd(10'h021, 1, 1, 1); step();
        chk("R11 per-lane priority", l_rdata, 16'h11EE);
        idle(); lwr(10'h030, 16'h1111, 1, 1); step();
        idle(); lrd(10'h030, 1, 1, 1); rwr(10'h030, 16'h2222, 1, 1); step();
        chk("R12 read before write", l_rdata, 16'h1111);
        idle(); lrd(10'h030, 1, 1, 1); step();
        chk("R12 later read new", l_rdata, 16'h2222);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_lanes();
        t_deselect();
        t_box_left();
        t_box_right();
        t_hold();
        t_priority();
        t_collide();
        idle(); step();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule